// File: doc/BRIEF.md
# Boxcar Moving Average with Circular History

This block computes a running average over the most recent 2^LOG_LEN signed samples. Every accepted sample is added to a running total. In the same cycle the sample that falls out of the window is subtracted. The window history lives in a small register-array memory used as a ring. One pointer both reads the oldest entry and writes the newest entry in its place, so a long window needs no shift chain.

A two-state fill controller keeps the result correct from the first sample after reset or clear:

- **ST_FILL**: taken after reset and after any clear. While the ring has not yet been written all the way round, zero is subtracted in place of the memory read data.
- **ST_FULL**: the ring is full, and the value read from memory is subtracted.

The transitions are:

- **fill_done**: ST_FILL to ST_FULL, on the accepted sample that fills the last slot.
- **hold_full**: ST_FULL stays in ST_FULL.
- **flush**: any state to ST_FILL, when the clear input is high.

The quotient is the running total shifted right arithmetically by LOG_LEN bits. This is a truncating divide by the window length, and it rounds toward negative infinity.

Top module: `boxcar_avg`

## Requirements
- R1: A sample accepted at clock edge k contributes to `out_avg` from edge k+1 on. `out_avg` equals floor(S / 2^LOG_LEN), where S is the sum of the last 2^LOG_LEN accepted samples.
- R2: While fewer than 2^LOG_LEN samples have been accepted since reset or clear, the window slots not yet written count as zero. For example, a single sample 8 gives 2 with LOG_LEN = 2.
- R3: In a cycle with `in_en` low, the sample is ignored. The history and the running total do not change, and `out_avg` stays stable.
- R4: `out_valid` is `in_en & ~clr` delayed by exactly two clock edges.
- R5: With `clr` high at an edge, the window is emptied and the total becomes zero, so `out_avg` reads 0 after the following edge. `clr` overrides `in_en`: a sample presented with `clr` is dropped and produces no valid pulse.
- R6: While `rst_n` is low, `out_avg` and `out_valid` are 0. After release the block behaves as after a clear.
- R7: Samples are two's complement. The divide truncates toward negative infinity. With LOG_LEN = 2, the inputs 1,2,3,4 give 2, the inputs 7,8,9,10 give 8, and the inputs -1,-2,-3,-4 give -3.
- R8: The ring pointer advances by one modulo 2^LOG_LEN on each accepted sample and holds otherwise. Once full, the window stays full until a clear, and each later sample evicts exactly the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of window and total |
| in_en | input | 1 | Sample enable |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Enable delayed by two edges |
| out_avg | output | DW | Signed truncated window average |

## Verification
A stale memory word that leaks into the total during ST_FILL skews `out_avg` on the edge after the first affected sample. The error then persists for as long as the window spans it. A pointer that skips or fails to wrap removes the wrong sample once the window is full, so the error appears from the 2^LOG_LEN+1-th sample on. Every cycle's output is compared against a software window model, across gaps in the enable, a clear in the middle of the stream, an asynchronous reset and negative data. A wrong clear priority shows up as a spurious valid pulse two edges later.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_t;

endpackage

// File: rtl/boxcar_ctrl.sv
module boxcar_ctrl
    import boxcar_pkg::*;
#(
    parameter int LOG_LEN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               in_en,
    output logic [LOG_LEN-1:0] ptr,
    output fill_state_t        state,
    output logic               use_old
);

    localparam logic [LOG_LEN-1:0] LAST_SLOT = {LOG_LEN{1'b1}};

    fill_state_t state_nxt;
    logic        accept;

    assign accept = in_en & ~clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: flush, fill_done, hold_full
    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = ST_FILL;
        end else begin
            unique case (state)
                ST_FILL: if (accept && ptr == LAST_SLOT) state_nxt = ST_FULL;
                ST_FULL: state_nxt = ST_FULL;
                default: state_nxt = ST_FILL;
            endcase
        end
    end

    // ring pointer, shared by read and write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (accept) begin
            ptr <= ptr + 1'b1;
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (state)
            ST_FILL: use_old = 1'b0;
            ST_FULL: use_old = 1'b1;
            default: use_old = 1'b0;
        endcase
    end

endmodule

// File: rtl/boxcar_hist.sv
module boxcar_hist #(
    parameter int DW      = 8,
    parameter int LOG_LEN = 2
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [LOG_LEN-1:0] addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data
);

    localparam int DEPTH = 1 << LOG_LEN;

    logic [DW-1:0] mem [DEPTH];

    // read the oldest entry before it is overwritten at the edge
    assign rd_data = mem[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

endmodule

// File: rtl/boxcar_acc.sv
module boxcar_acc #(
    parameter int DW      = 8,
    parameter int LOG_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_en,
    input  logic [DW-1:0] in_sample,
    input  logic [DW-1:0] old_sample,
    input  logic          use_old,
    output logic [DW-1:0] out_avg,
    output logic          out_valid
);

    localparam int AW = DW + LOG_LEN;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] add_term;
    logic signed [AW-1:0] sub_term;
    logic                 valid_d1;

    assign add_term = AW'($signed(in_sample));
    assign sub_term = use_old ? AW'($signed(old_sample)) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (in_en) begin
            acc <= acc + add_term - sub_term;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_avg   <= '0;
            valid_d1  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_avg   <= acc[AW-1:LOG_LEN];
            valid_d1  <= in_en & ~clr;
            out_valid <= valid_d1;
        end
    end

endmodule

// File: rtl/boxcar_avg.sv
module boxcar_avg
    import boxcar_pkg::*;
#(
    parameter int DW      = 8,
    parameter int LOG_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_en,
    input  logic [DW-1:0] in_sample,
    output logic          out_valid,
    output logic [DW-1:0] out_avg
);

    logic [LOG_LEN-1:0] ptr;
    fill_state_t        state;
    logic               use_old;
    logic [DW-1:0]      old_sample;

    boxcar_ctrl #(.LOG_LEN(LOG_LEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .in_en   (in_en),
        .ptr     (ptr),
        .state   (state),
        .use_old (use_old)
    );

    boxcar_hist #(.DW(DW), .LOG_LEN(LOG_LEN)) u_hist (
        .clk     (clk),
        .wr_en   (in_en & ~clr),
        .addr    (ptr),
        .wr_data (in_sample),
        .rd_data (old_sample)
    );

    boxcar_acc #(.DW(DW), .LOG_LEN(LOG_LEN)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .in_en      (in_en),
        .in_sample  (in_sample),
        .old_sample (old_sample),
        .use_old    (use_old),
        .out_avg    (out_avg),
        .out_valid  (out_valid)
    );

endmodule

// File: rtl/boxcar_avg_chk.sv
module boxcar_avg_chk
    import boxcar_pkg::*;
#(
    parameter int DW      = 8,
    parameter int LOG_LEN = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic               in_en,
    input logic               out_valid,
    input logic [DW-1:0]      out_avg,
    input logic [LOG_LEN-1:0] ptr,
    input fill_state_t        state
);

    AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en && !clr) |=> ##1 out_valid); // R4
    AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_en && !clr) |=> ##1 !out_valid); // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ##1 (out_avg == '0)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_en && !clr) |=> ##1 $stable(out_avg)); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en && !clr) |=> (ptr == LOG_LEN'($past(ptr) + 1'b1))); // R8
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_en && !clr) |=> $stable(ptr)); // R8
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !clr) |=> (state == ST_FULL)); // R8

endmodule

bind boxcar_avg boxcar_avg_chk #(.DW(DW), .LOG_LEN(LOG_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_en     (in_en),
    .out_valid (out_valid),
    .out_avg   (out_avg),
    .ptr       (ptr),
    .state     (state)
);

// File: tb/test_boxcar_avg.sv
module test_boxcar_avg;

    localparam int DW = 8;
    localparam int LOG_LEN = 2;
    localparam int N = 1 << LOG_LEN;
    localparam int NV = 24;

    // {en, clr, sample}
    localparam logic [9:0] VEC [NV] = '{
        10'h205, 10'h20A, 10'h000, 10'h2F0, 10'h27F, 10'h280,
        10'h000, 10'h000, 10'h203, 10'h2FF, 10'h212, 10'h2C0,
        10'h340, 10'h000, 10'h221, 10'h000, 10'h2EE, 10'h100,
        10'h27F, 10'h27F, 10'h27F, 10'h27F, 10'h27F, 10'h000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic in_en = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic out_valid;
    logic [DW-1:0] out_avg;

    int checks = 0;
    int failures = 0;

    int m_hist [N];
    int m_cnt = 0;
    int m_wp = 0;
    int m_sum = 0;
    logic m_v1 = 1'b0;
    int exp_out = 0;
    logic exp_valid = 1'b0;

    always #4 clk = ~clk;

    boxcar_avg #(.DW(DW), .LOG_LEN(LOG_LEN)) i_boxcar_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_en     (in_en),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_avg   (out_avg)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_cnt = 0;
        m_wp = 0;
        m_sum = 0;
    endtask

    task automatic step(input logic en, input logic c, input logic [DW-1:0] x);
        int xs;
        int old;
        @(negedge clk);
        in_en = en;
        clr = c;
        in_sample = x;
        @(posedge clk);
        exp_out = m_sum >>> LOG_LEN;
        exp_valid = m_v1;
        m_v1 = en && !c;
        if (c) begin
            model_clear();
        end else if (en) begin
            xs = int'($signed(x));
            old = (m_cnt >= N) ? m_hist[m_wp] : 0;
            m_sum = m_sum + xs - old;
            m_hist[m_wp] = xs;
            m_wp = (m_wp + 1) % N;
            if (m_cnt < N) m_cnt++;
        end
        #2;
        check("R1 avg", int'($signed(out_avg)), exp_out);
        check("R4 valid", int'(out_valid), int'(exp_valid));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_en = 1'b0;
        clr = 1'b0;
        #2;
        check("R6 avg in reset", int'(out_avg), 0);
        check("R6 valid in reset", int'(out_valid), 0);
        model_clear();
        m_v1 = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        // table walk: gaps, negatives, wrap, clear with enable (R2 R3 R5 R8)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][9], VEC[i][8], VEC[i][7:0]);
        end

        // R7: 1,2,3,4 -> 2, then 7..10 -> 8
        step(1'b0, 1'b1, 8'd0);
        step(1'b1, 1'b0, 8'd1);
        step(1'b1, 1'b0, 8'd2);
        step(1'b1, 1'b0, 8'd3);
        step(1'b1, 1'b0, 8'd4);
        step(1'b0, 1'b0, 8'd0);
        check("R7 1..4", int'($signed(out_avg)), 2);
        step(1'b1, 1'b0, 8'd5);
        step(1'b1, 1'b0, 8'd6);
        step(1'b1, 1'b0, 8'd7);
        step(1'b1, 1'b0, 8'd8);
        step(1'b1, 1'b0, 8'd9);
        step(1'b1, 1'b0, 8'd10);
        step(1'b0, 1'b0, 8'd0);
        check("R8 wrap 7..10", int'($signed(out_avg)), 8);

        // R3: long idle keeps output
        step(1'b0, 1'b0, 8'h55);
        step(1'b0, 1'b0, 8'hAA);
        check("R3 idle hold", int'($signed(out_avg)), 8);

        // R5: clear empties window
        step(1'b0, 1'b1, 8'd0);
        step(1'b0, 1'b0, 8'd0);
        check("R5 clear zero", int'($signed(out_avg)), 0);

        // R2: single sample after clear
        step(1'b1, 1'b0, 8'd8);
        step(1'b0, 1'b0, 8'd0);
        check("R2 partial fill", int'($signed(out_avg)), 2);

        // R7: negative floor
        step(1'b0, 1'b1, 8'd0);
        step(1'b1, 1'b0, 8'hFF);
        step(1'b1, 1'b0, 8'hFE);
        step(1'b1, 1'b0, 8'hFD);
        step(1'b1, 1'b0, 8'hFC);
        step(1'b0, 1'b0, 8'd0);
        check("R7 negative floor", int'($signed(out_avg)), -3);

        // R6: reset mid stream, then restart from empty
        step(1'b1, 1'b0, 8'd40);
        do_reset();
        step(1'b1, 1'b0, 8'd12);
        step(1'b0, 1'b0, 8'd0);
        check("R6 restart empty", int'($signed(out_avg)), 3);
        step(1'b0, 1'b0, 8'd0);
        step(1'b0, 1'b0, 8'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule